// File: doc/BRIEF.md
# Conservative Open-Page Decision Unit

This unit sits between a request queue and the command pattern sequencer of a real-time SDRAM controller. When a request's pattern starts, the unit records the bank, row and direction of that request. It marks the bank's row as open. It then counts down to the last cycle on which a precharge can still be issued without delaying the next activate. That deadline is the activate-to-activate span of the pattern minus the precharge-to-activate distance. With a span of 38 cycles and a precharge-to-activate distance of 10, the window is 28 cycles long.

At the deadline the unit makes one decision. The row is kept open only if the queue head was seen, strictly before the deadline, to target the same bank, row and direction. In that case the precharge and the next activate are both skipped, and the sequencer is told to use the read/write-only bypass pattern. In every other case the precharge is issued, the full pattern is selected and the bank's open flag is cleared. Worst-case service is therefore the same as a close-page policy. Requests with locality finish sooner on average.

Both timing values are inputs, so pattern reconfiguration is followed. They are captured when a pattern starts.

Top module: `cop_decision_unit`

## Requirements
- R1: After reset, `dec_valid`, `dec_pre` and `dec_skip` are 0 and every bit of `row_open` is 0.
- R2: In the cycle after `cur_start` is sampled high, bit `cur_bank` of `row_open` is 1.
- R3: The window length W is `cfg_span - cfg_pre2act`, or 0 if `cfg_pre2act >= cfg_span`. Take the edge that samples `cur_start` as edge 0. `dec_valid` is then high for exactly one cycle, following edge W+1, and `dec_bank` equals the current request's bank.
- R4: A next request sampled with `nxt_valid` high at any edge 1..W is a hit when its bank, row and direction (`we`, 1 = write) all equal the current request's. A hit gives `dec_skip`=1, `dec_pre`=0 and `pat_sel`=1 (bypass pattern).
- R5: A next request that differs only in row gives `dec_pre`=1, `dec_skip`=0 and `pat_sel`=0 (full pattern).
- R6: A next request that differs only in bank, or only in direction, gives a precharge.
- R7: With no next request in the window, the decision is a precharge.
- R8: A next request sampled at edge W+1, the closing edge, is too late and gives a precharge.
- R9: A precharge clears the decided bank's bit in `row_open` in the same cycle as `dec_valid`; a skip leaves it set.
- R10: While `dec_valid` is high, exactly one of `dec_pre` and `dec_skip` is high; while it is low, both are low.
- R11: Changing `cfg_span` or `cfg_pre2act` after edge 0 does not move the decision of the running pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_span | input | CNT_W | Activate-to-activate span of the pattern, in cycles |
| cfg_pre2act | input | CNT_W | Precharge-to-activate distance, in cycles |
| cur_start | input | 1 | Pulse: the current request's pattern starts |
| cur_bank | input | BANK_W | Bank of the current request |
| cur_row | input | ROW_W | Row of the current request |
| cur_we | input | 1 | Direction of the current request (1 = write) |
| nxt_valid | input | 1 | Queue head is known |
| nxt_bank | input | BANK_W | Bank of the queue head |
| nxt_row | input | ROW_W | Row of the queue head |
| nxt_we | input | 1 | Direction of the queue head |
| dec_valid | output | 1 | Decision strobe |
| dec_pre | output | 1 | Issue the precharge |
| dec_skip | output | 1 | Keep the row open, skip precharge and activate |
| dec_bank | output | BANK_W | Bank the decision applies to |
| pat_sel | output | 1 | Pattern for the next request: 0 full, 1 bypass |
| row_open | output | NBANK | One bit per bank: a row is held open |

## Verification
The bench places the queue head on the last edge that still counts (edge W) and on the closing edge W+1. An off-by-one deadline would either keep rows open that the worst-case analysis treats as closed, or throw away hits. It varies bank, row and direction one at a time. A comparator that ignores one field would bypass into the wrong row or in the wrong direction. It also alters the configuration mid-window and uses a window of zero length. A design that reads the configuration live, or that does not saturate the subtraction, would decide at the wrong time.

// File: rtl/cop_pkg.sv
package cop_pkg;
  typedef enum logic {
    PAT_FULL   = 1'b0,
    PAT_BYPASS = 1'b1
  } pat_sel_e;
endpackage

// File: rtl/cop_window_timer.sv
module cop_window_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] span,
  input  logic [CNT_W-1:0] pre2act,
  output logic             in_window,
  output logic             deadline
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] win_q;
  logic [CNT_W-1:0] win_d;

  // Window closes where a deferred precharge still meets the next activate
  assign win_d = (span > pre2act) ? (span - pre2act) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      win_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      win_q    <= win_d;
    end else if (active_q) begin
      if (cnt_q == win_q) active_q <= 1'b0;
      else                cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign in_window = active_q && (cnt_q < win_q);
  assign deadline  = active_q && (cnt_q == win_q);
endmodule

// File: rtl/cop_bank_table.sv
module cop_bank_table #(
  parameter int NBANK = 8,
  parameter int ROW_W = 14,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [BANK_W-1:0] set_bank,
  input  logic [ROW_W-1:0]  set_row,
  input  logic              clr_en,
  input  logic [BANK_W-1:0] clr_bank,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  output logic              look_hit,
  output logic [NBANK-1:0]  open_vec
);
  logic [ROW_W-1:0] rows [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        open_vec[b] <= 1'b0;
        rows[b]     <= '0;
      end else if (set_en && set_bank == BANK_W'(b)) begin
        open_vec[b] <= 1'b1;
        rows[b]     <= set_row;
      end else if (clr_en && clr_bank == BANK_W'(b)) begin
        open_vec[b] <= 1'b0;
      end
    end
  end

  assign look_hit = open_vec[look_bank] && (rows[look_bank] == look_row);
endmodule

// File: rtl/cop_hit_detect.sv
module cop_hit_detect #(
  parameter int NBANK = 8,
  parameter int ROW_W = 14,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              start_we,
  input  logic              in_window,
  input  logic              nxt_valid,
  input  logic [BANK_W-1:0] nxt_bank,
  input  logic              nxt_we,
  input  logic              row_match,
  output logic [BANK_W-1:0] cur_bank_q,
  output logic              hit_q
);
  logic cur_we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_bank_q <= '0;
      cur_we_q   <= 1'b0;
      hit_q      <= 1'b0;
    end else if (start) begin
      cur_bank_q <= start_bank;
      cur_we_q   <= start_we;
      hit_q      <= 1'b0;
    end else if (in_window && nxt_valid && row_match &&
                 nxt_bank == cur_bank_q && nxt_we == cur_we_q) begin
      hit_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cop_decision_unit.sv
module cop_decision_unit
  import cop_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int ROW_W = 14,
  parameter int CNT_W = 8,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_span,
  input  logic [CNT_W-1:0]  cfg_pre2act,
  input  logic              cur_start,
  input  logic [BANK_W-1:0] cur_bank,
  input  logic [ROW_W-1:0]  cur_row,
  input  logic              cur_we,
  input  logic              nxt_valid,
  input  logic [BANK_W-1:0] nxt_bank,
  input  logic [ROW_W-1:0]  nxt_row,
  input  logic              nxt_we,
  output logic              dec_valid,
  output logic              dec_pre,
  output logic              dec_skip,
  output logic [BANK_W-1:0] dec_bank,
  output logic              pat_sel,
  output logic [NBANK-1:0]  row_open
);
  logic              in_window;
  logic              deadline;
  logic              row_match;
  logic              hit_q;
  logic [BANK_W-1:0] act_bank;
  logic              decide;
  logic              do_pre;

  cop_window_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .start(cur_start),
    .span(cfg_span), .pre2act(cfg_pre2act),
    .in_window(in_window), .deadline(deadline)
  );

  cop_bank_table #(.NBANK(NBANK), .ROW_W(ROW_W)) u_table (
    .clk(clk), .rst(rst),
    .set_en(cur_start), .set_bank(cur_bank), .set_row(cur_row),
    .clr_en(do_pre), .clr_bank(act_bank),
    .look_bank(nxt_bank), .look_row(nxt_row),
    .look_hit(row_match), .open_vec(row_open)
  );

  cop_hit_detect #(.NBANK(NBANK), .ROW_W(ROW_W)) u_hit (
    .clk(clk), .rst(rst),
    .start(cur_start), .start_bank(cur_bank), .start_we(cur_we),
    .in_window(in_window), .nxt_valid(nxt_valid),
    .nxt_bank(nxt_bank), .nxt_we(nxt_we), .row_match(row_match),
    .cur_bank_q(act_bank), .hit_q(hit_q)
  );

  // A new pattern start abandons the running window
  assign decide = deadline && !cur_start;
  assign do_pre = decide && !hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_pre   <= 1'b0;
      dec_skip  <= 1'b0;
      dec_bank  <= '0;
      pat_sel   <= PAT_FULL;
    end else begin
      dec_valid <= decide;
      dec_pre   <= do_pre;
      dec_skip  <= decide && hit_q;
      if (decide) begin
        dec_bank <= act_bank;
        pat_sel  <= hit_q ? PAT_BYPASS : PAT_FULL;
      end
    end
  end
endmodule

// File: rtl/cop_decision_unit_chk.sv
module cop_decision_unit_chk #(
  parameter int NBANK = 8,
  localparam int BANK_W = $clog2(NBANK)
) (
  input logic              clk,
  input logic              rst,
  input logic              cur_start,
  input logic [BANK_W-1:0] cur_bank,
  input logic              dec_valid,
  input logic              dec_pre,
  input logic              dec_skip,
  input logic [BANK_W-1:0] dec_bank,
  input logic              pat_sel,
  input logic [NBANK-1:0]  row_open
);
  AST_ONE_OF: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_pre ^ dec_skip)); // R10
  AST_QUIET: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!dec_pre && !dec_skip)); // R10
  AST_PAT_MATCH: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (pat_sel == dec_skip)); // R4
  AST_PRE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_pre) |-> !row_open[dec_bank]); // R9
  AST_SKIP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_skip) |-> row_open[dec_bank]); // R9
  AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
    cur_start |=> row_open[$past(cur_bank)]); // R2
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid); // R3
endmodule

bind cop_decision_unit cop_decision_unit_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst(rst), .cur_start(cur_start), .cur_bank(cur_bank),
  .dec_valid(dec_valid), .dec_pre(dec_pre), .dec_skip(dec_skip),
  .dec_bank(dec_bank), .pat_sel(pat_sel), .row_open(row_open)
);

// File: tb/cop_decision_unit_tb.sv
module cop_decision_unit_tb;
  localparam int NBANK = 8;
  localparam int ROW_W = 14;
  localparam int CNT_W = 8;
  localparam int BANK_W = $clog2(NBANK);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0]  cfg_span = '0, cfg_pre2act = '0;
  logic              cur_start = 1'b0, cur_we = 1'b0;
  logic [BANK_W-1:0] cur_bank = '0;
  logic [ROW_W-1:0]  cur_row = '0;
  logic              nxt_valid = 1'b0, nxt_we = 1'b0;
  logic [BANK_W-1:0] nxt_bank = '0;
  logic [ROW_W-1:0]  nxt_row = '0;
  logic              dec_valid, dec_pre, dec_skip, pat_sel;
  logic [BANK_W-1:0] dec_bank;
  logic [NBANK-1:0]  row_open;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cop_decision_unit #(.NBANK(NBANK), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_span(cfg_span), .cfg_pre2act(cfg_pre2act),
    .cur_start(cur_start), .cur_bank(cur_bank), .cur_row(cur_row), .cur_we(cur_we),
    .nxt_valid(nxt_valid), .nxt_bank(nxt_bank), .nxt_row(nxt_row), .nxt_we(nxt_we),
    .dec_valid(dec_valid), .dec_pre(dec_pre), .dec_skip(dec_skip),
    .dec_bank(dec_bank), .pat_sel(pat_sel), .row_open(row_open)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One pattern: start at edge 0, queue head present only at edge `arrive`
  task automatic run_case(input string req, input int span, input int p2a,
                          input int cb, input int cr, input bit cw,
                          input int nb, input int nr, input bit nw,
                          input int arrive, input bit exp_skip, input bit late_cfg);
    int win;
    int seen_at;
    bit s_pre, s_skip, s_pat;
    int s_bank;
    win = (span > p2a) ? span - p2a : 0;
    seen_at = -1;
    s_pre = 0; s_skip = 0; s_pat = 0; s_bank = -1;
    cfg_span = CNT_W'(span); cfg_pre2act = CNT_W'(p2a);
    cur_bank = BANK_W'(cb); cur_row = ROW_W'(cr); cur_we = cw;
    nxt_bank = BANK_W'(nb); nxt_row = ROW_W'(nr); nxt_we = nw;
    cur_start = 1'b1;
    @(negedge clk);
    cur_start = 1'b0;
    if (late_cfg) begin
      cfg_span = CNT_W'(60); cfg_pre2act = CNT_W'(0);
    end
    check(row_open[cb] == 1'b1, "R2 bank opened", int'(row_open[cb]), 1);
    for (int e = 1; e <= win + 3; e++) begin
      nxt_valid = (e == arrive);
      @(negedge clk);
      if (dec_valid) begin
        if (seen_at < 0) seen_at = e;
        else seen_at = -2;
        s_pre = dec_pre; s_skip = dec_skip; s_pat = pat_sel; s_bank = int'(dec_bank);
        check(row_open[cb] == exp_skip, "R9 open bit at decision", int'(row_open[cb]), int'(exp_skip));
      end
    end
    nxt_valid = 1'b0;
    check(seen_at == win + 1, {req, "/R3 decision cycle"}, seen_at, win + 1);
    check(s_bank == cb, "R3 decided bank", s_bank, cb);
    check(s_skip == exp_skip && s_pre == !exp_skip, {req, " skip/pre"},
          int'(s_skip), int'(exp_skip));
    check(s_pat == exp_skip, {req, " pattern select"}, int'(s_pat), int'(exp_skip));
    check(row_open[cb] == exp_skip, "R9 open bit after", int'(row_open[cb]), int'(exp_skip));
  endtask

  task automatic t_reset();
    check(dec_valid == 0 && dec_pre == 0 && dec_skip == 0, "R1 decision idle",
          int'(dec_valid), 0);
    check(row_open == '0, "R1 no open rows", int'(row_open), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // window 8: span 12, pre-to-act 4
    run_case("R4 early hit",       12, 4, 2, 100, 0, 2, 100, 0, 3, 1'b1, 1'b0);
    run_case("R4 hit at last edge",12, 4, 3, 7,   1, 3, 7,   1, 8, 1'b1, 1'b0);
    run_case("R8 closing edge",    12, 4, 3, 7,   1, 3, 7,   1, 9, 1'b0, 1'b0);
    run_case("R5 row differs",     12, 4, 1, 50,  0, 1, 51,  0, 2, 1'b0, 1'b0);
    run_case("R6 bank differs",    12, 4, 4, 50,  0, 5, 50,  0, 2, 1'b0, 1'b0);
    run_case("R6 dir differs",     12, 4, 4, 50,  0, 4, 50,  1, 2, 1'b0, 1'b0);
    run_case("R7 no next",         12, 4, 6, 9,   1, 6, 9,   1, 0, 1'b0, 1'b0);
    run_case("R11 cfg changed",    12, 4, 0, 11,  0, 0, 11,  0, 5, 1'b1, 1'b1);
    // window 28 from span 38 and pre-to-act 10
    run_case("R4 long window",     38, 10, 7, 300, 1, 7, 300, 1, 28, 1'b1, 1'b0);
    // saturated window of zero length: head at edge 1 is too late
    run_case("R3 zero window",     4, 9, 5, 12,  0, 5, 12,  0, 1, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule